// File: doc/BRIEF.md
# Wake-up counter with threshold interrupt

This block counts the periodic wake-ups of a low-power radio controller and tells the host when a programmed number of them has gone by. The radio can then take over the timing of the host's own sleep. Each cycle in which `wake_i` is high counts as one hardware wake-up, provided that wake-up on timeout is armed. The host programs the block through a byte-wide register port. This port holds a configuration byte, an interrupt mask, a status byte, a 16-bit running count and a 16-bit threshold.

The block adds one to the count on every armed wake-up and compares the new value with the threshold. When the new value is strictly greater than the threshold, the count returns to zero. In that same cycle, if the wake-up interrupt is unmasked, the block latches its interrupt output and sends a one-cycle request to enter the off state. So a threshold of N gives an event on the (N+1)th wake-up. The oscillator-enable, clock-select and backup-RAM power fields of the configuration byte come out as plain level signals for the power logic around the block.

Register addresses: 0x100 mask, 0x101 status, 0x102/0x103 count, 0x104/0x105 threshold and 0x106 configuration. Every 16-bit register keeps its high byte at the lower address.

Top module: `wake_timer_irq`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_o`, `off_req_o` and all configuration outputs are low.
- R2: With configuration bit 0 (arm) set, each cycle with `wake_i` high adds one to the count, unless R4 applies.
- R3: With configuration bit 0 clear, `wake_i` has no effect on the count, the interrupt or the off request.
- R4: When count+1 is greater than the threshold, the count becomes 0 instead. Equality does not clear it. Count 0xFFFF with threshold 0xFFFF also clears.
- R5: On an R4 clear with mask (0x100) bit 0 set, `irq_o` goes high after the same clock edge. With mask bit 0 clear, `irq_o` does not change.
- R6: `off_req_o` is high for exactly the cycle after each unmasked R4 clear, and low at all other times.
- R7: `irq_o` stays high until a write to status (0x101) with bit 0 set. A write with bit 0 clear leaves it high. If a new event and a clear come in the same cycle, the event wins. Status bit 0 reads `irq_o`.
- R8: A configuration write (0x106) stores bits 6,5,4,3,0 only. Bits 7,2,1 read as 0. Bit 6 drives `rc_osc_en_o`, bit 5 drives `xtal_en_o`, bit 4 drives `clk_sel_rc_o` (1 = internal RC) and bit 3 drives `bkram_pwr_o`.
- R9: The threshold is written and read as bytes, high at 0x104 and low at 0x105. A new byte takes effect for the next wake-up.
- R10: The count reads high at 0x102 and low at 0x103. A read of 0x102 captures the low byte, and later reads of 0x103 return that captured value.
- R11: The mask register stores and reads back all 8 bits. Only bit 0 gates the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wake_i | input | 1 | Wake-up timeout pulse, one count per high cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 10 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from address |
| irq_o | output | 1 | Latched host interrupt |
| off_req_o | output | 1 | One-cycle off-state request |
| rc_osc_en_o | output | 1 | RC oscillator enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| clk_sel_rc_o | output | 1 | Clock select, 1 = RC |
| bkram_pwr_o | output | 1 | Backup RAM power during sleep |

## Verification
Directed runs with thresholds 2 and 0 tell a clear on "greater than" apart from a clear on "equal". A full 65536-wake run at threshold 0xFFFF covers the 16-bit carry. Runs with the mask on and off separate the interrupt gating from the counting itself. A random mix then interleaves wake pulses, arm toggles, threshold byte writes, clears and split count reads. This exposes wrong ordering between a same-cycle threshold write and a compare, between an event and a clear, and between a latched low byte and a count that has moved on.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = 16;

  localparam logic [ADDR_W-1:0] A_MASK   = 10'h100;
  localparam logic [ADDR_W-1:0] A_STAT   = 10'h101;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 10'h102;
  localparam logic [ADDR_W-1:0] A_THR_HI = 10'h104;
  localparam logic [ADDR_W-1:0] A_CFG    = 10'h106;

  typedef struct packed {
    logic       rsv7;
    logic       rc_en;
    logic       xtal_en;
    logic       clk_rc;
    logic       bkram;
    logic [1:0] rsv21;
    logic       arm;
  } cfg_t;

  localparam logic [DATA_W-1:0] CFG_WMASK = 8'h79;
endpackage

// File: rtl/wake_counter.sv
module wake_counter
  import wake_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wake_i,
  input  logic         arm_i,
  input  logic [W-1:0] thr_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;
  logic         hit;

  assign hit    = wake_i & arm_i;
  assign nxt    = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  // strictly greater, 17-bit so 0xFFFF+1 compares correctly
  assign wrap_o = hit & (nxt > {1'b0, thr_i});
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (hit)    cnt_q <= nxt[W-1:0];
  end

  // R2
  incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !wrap_o) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R3
  unarmed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(cnt_q));
  // R4
  wrap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == '0);
endmodule

// File: rtl/wake_irq.sv
module wake_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic mask_en_i,
  input  logic clr_i,
  output logic irq_o,
  output logic off_req_o
);
  logic irq_q, off_q, evt;

  assign evt = wrap_i & mask_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      off_q <= 1'b0;
    end else begin
      off_q <= evt;
      if (evt)        irq_q <= 1'b1;  // event beats clear
      else if (clr_i) irq_q <= 1'b0;
    end
  end

  assign irq_o     = irq_q;
  assign off_req_o = off_q;

  // R6
  off_with_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |-> irq_q);
  // R7
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q);
  // R5
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && !evt) |=> !irq_q);
endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [W-1:0]      cnt_i,
  input  logic              irq_i,
  output logic [DATA_W-1:0] rdata_o,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [W-1:0]      thr_o,
  output logic              irq_clr_o
);
  localparam int unsigned NB = W / DATA_W;
  localparam int unsigned SW = W - DATA_W;

  logic [DATA_W-1:0] cfg_q, mask_q;
  logic [W-1:0]      thr_q;
  logic [SW-1:0]     shadow_q;
  logic [W-1:0]      cnt_view;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else if (wr_i) begin
      if (addr_i == A_CFG)  cfg_q  <= wdata_i & CFG_WMASK;
      if (addr_i == A_MASK) mask_q <= wdata_i;
    end
  end

  // threshold byte lanes, big-endian addressing
  for (genvar b = 0; b < NB; b++) begin : g_thr
    localparam logic [ADDR_W-1:0] LANE_A = ADDR_W'(A_THR_HI + (NB - 1 - b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         thr_q[b*DATA_W +: DATA_W] <= '0;
      else if (wr_i && addr_i == LANE_A)   thr_q[b*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  // high-byte read snapshots the lower bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         shadow_q <= '0;
    else if (rd_i && addr_i == A_CNT_HI) shadow_q <= cnt_i[SW-1:0];
  end

  assign cnt_view  = {cnt_i[W-1 -: DATA_W], shadow_q};
  assign irq_clr_o = wr_i && (addr_i == A_STAT) && wdata_i[0];

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_MASK) rdata_o = mask_q;
    if (addr_i == A_STAT) rdata_o = {{(DATA_W-1){1'b0}}, irq_i};
    if (addr_i == A_CFG)  rdata_o = cfg_q;
    for (int b = 0; b < int'(NB); b++) begin
      if (addr_i == ADDR_W'(A_CNT_HI + (NB - 1 - b))) rdata_o = cnt_view[b*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(A_THR_HI + (NB - 1 - b))) rdata_o = thr_q[b*DATA_W +: DATA_W];
    end
  end

  assign cfg_o  = cfg_t'(cfg_q);
  assign mask_o = mask_q;
  assign thr_o  = thr_q;

  // R8
  cfg_rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_CFG) |=> (cfg_q & ~CFG_WMASK) == '0);
  // R10
  shadow_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_CNT_HI) |=> shadow_q == $past(cnt_i[SW-1:0]));
endmodule

// File: rtl/wake_timer_irq.sv
module wake_timer_irq
  import wake_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wake_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              off_req_o,
  output logic              rc_osc_en_o,
  output logic              xtal_en_o,
  output logic              clk_sel_rc_o,
  output logic              bkram_pwr_o
);
  cfg_t              cfg;
  logic [DATA_W-1:0] mask;
  logic [CNT_W-1:0]  thr, cnt;
  logic              wrap, irq_clr, irq;

  wake_regs #(.W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .cnt_i     (cnt),
    .irq_i     (irq),
    .rdata_o   (reg_rdata_o),
    .cfg_o     (cfg),
    .mask_o    (mask),
    .thr_o     (thr),
    .irq_clr_o (irq_clr)
  );

  wake_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wake_i (wake_i),
    .arm_i  (cfg.arm),
    .thr_i  (thr),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  wake_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wrap_i    (wrap),
    .mask_en_i (mask[0]),
    .clr_i     (irq_clr),
    .irq_o     (irq),
    .off_req_o (off_req_o)
  );

  assign irq_o        = irq;
  assign rc_osc_en_o  = cfg.rc_en;
  assign xtal_en_o    = cfg.xtal_en;
  assign clk_sel_rc_o = cfg.clk_rc;
  assign bkram_pwr_o  = cfg.bkram;
endmodule

// File: tb/sim_wake_timer_irq.sv
`timescale 1ns/1ps
module sim_wake_timer_irq;
  logic       clk = 0, rst_n = 0;
  logic       wake = 0, wr = 0, rd = 0;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, off, rc_en, xt_en, clk_rc, bkram;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_cnt, m_thr;
  logic [7:0]  m_cfg, m_mask, m_shadow;
  logic        m_irq, m_off;

  always #4 clk = ~clk;

  wake_timer_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wake_i(wake), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .off_req_o(off), .rc_osc_en_o(rc_en), .xtal_en_o(xt_en),
    .clk_sel_rc_o(clk_rc), .bkram_pwr_o(bkram)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [9:0] a);
    case (a)
      10'h100: return m_mask;
      10'h101: return {7'b0, m_irq};
      10'h102: return m_cnt[15:8];
      10'h103: return m_shadow;
      10'h104: return m_thr[15:8];
      10'h105: return m_thr[7:0];
      10'h106: return m_cfg;
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input logic wk, input logic w, input logic r,
                      input logic [9:0] a, input logic [7:0] d, input string req);
    logic [16:0] nxt;
    logic fire;
    @(negedge clk);
    wake = wk; wr = w; rd = r; addr = a; wdata = d;
    #1;
    if (r) chk(rdata, exp_rd(a), req);
    @(posedge clk);
    fire = 0;
    if (wk && m_cfg[0]) begin
      nxt = {1'b0, m_cnt} + 17'd1;
      if (nxt > {1'b0, m_thr}) begin m_cnt_shadow_upd(r, a); m_cnt = '0; fire = 1; end
      else begin m_cnt_shadow_upd(r, a); m_cnt = nxt[15:0]; end
    end else m_cnt_shadow_upd(r, a);
    m_off = fire && m_mask[0];
    if (m_off) m_irq = 1;
    else if (w && a == 10'h101 && d[0]) m_irq = 0;
    if (w) begin
      if (a == 10'h100) m_mask = d;
      if (a == 10'h104) m_thr[15:8] = d;
      if (a == 10'h105) m_thr[7:0] = d;
      if (a == 10'h106) m_cfg = d & 8'h79;
    end
    #1;
    chk(irq, m_irq, "R5/R7 irq");
    chk(off, m_off, "R6 off_req");
    chk({rc_en, xt_en, clk_rc, bkram}, {m_cfg[6], m_cfg[5], m_cfg[4], m_cfg[3]}, "R8 cfg outs");
  endtask

  task automatic m_cnt_shadow_upd(input logic r, input logic [9:0] a);
    if (r && a == 10'h102) m_shadow = m_cnt[7:0];
  endtask

  task automatic wr_reg(input logic [9:0] a, input logic [7:0] d, input string req);
    step(0, 1, 0, a, d, req);
  endtask
  task automatic rd_reg(input logic [9:0] a, input string req);
    step(0, 0, 1, a, 8'h00, req);
  endtask

  initial begin
    #(190000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_cnt = 0; m_thr = 0; m_cfg = 0; m_mask = 0; m_shadow = 0; m_irq = 0; m_off = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk({irq, off, rc_en, xt_en, clk_rc, bkram}, 6'b0, "R1 outputs");
    rst_n = 1;
    for (int a = 'h100; a <= 'h106; a++) rd_reg(10'(a), "R1 reset regs");

    // R8 reserved bits
    wr_reg(10'h106, 8'hFF, "R8");
    rd_reg(10'h106, "R8 cfg=79");
    wr_reg(10'h106, 8'h00, "R8");
    // R11 mask full readback
    wr_reg(10'h100, 8'hA4, "R11");
    rd_reg(10'h100, "R11 mask");

    // R3 unarmed wakes ignored
    for (int i = 0; i < 5; i++) step(1, 0, 0, 10'h0, 8'h0, "R3");
    rd_reg(10'h102, "R3 cnt hi"); rd_reg(10'h103, "R3 cnt lo");

    // R4/R5 masked off: thr=2, third wake clears, no irq (mask bit0 = 0)
    wr_reg(10'h106, 8'h01, "R2");
    wr_reg(10'h105, 8'h02, "R9");
    rd_reg(10'h105, "R9 thr lo");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 10'h0, 8'h0, "R4 masked");
    rd_reg(10'h102, "R4"); rd_reg(10'h103, "R4 cleared");

    // unmasked: event, off pulse, irq holds
    wr_reg(10'h100, 8'h01, "R11");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 10'h0, 8'h0, "R5 unmasked");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 10'h0, 8'h0, "R6 hold");
    rd_reg(10'h101, "R7 status");
    wr_reg(10'h101, 8'hFE, "R7 write0 no clear");
    wr_reg(10'h101, 8'h01, "R7 clear");
    // threshold 0: every wake fires; event vs clear same cycle
    wr_reg(10'h105, 8'h00, "R9");
    step(1, 1, 0, 10'h101, 8'h01, "R7 event wins");
    step(1, 0, 0, 10'h0, 8'h0, "R6 back-to-back");

    // R4 full 16-bit at threshold 0xFFFF
    wr_reg(10'h104, 8'hFF, "R9");
    wr_reg(10'h105, 8'hFF, "R9");
    wr_reg(10'h101, 8'h01, "R7");
    for (int i = 0; i < 65535; i++) step(1, 0, 0, 10'h0, 8'h0, "R2 long run");
    rd_reg(10'h102, "R10 hi FF"); rd_reg(10'h103, "R10 lo FF");
    step(1, 0, 0, 10'h0, 8'h0, "R4 0xFFFF wrap");
    rd_reg(10'h102, "R4"); rd_reg(10'h103, "R4 zero");

    // random mix, fixed seed
    void'($urandom(32'h5EED));
    wr_reg(10'h104, 8'h00, "R9");
    for (int i = 0; i < 4000; i++) begin
      int unsigned k;
      k = $urandom_range(0, 15);
      case (k)
        0:  wr_reg(10'h105, 8'($urandom_range(0, 12)), "R9 rnd");
        1:  wr_reg(10'h106, 8'($urandom), "R8 rnd");
        2:  wr_reg(10'h100, 8'($urandom), "R11 rnd");
        3:  wr_reg(10'h101, 8'($urandom), "R7 rnd");
        4:  rd_reg(10'h102, "R10 rnd hi");
        5:  rd_reg(10'h103, "R10 rnd lo");
        6:  step(1, 1, 0, 10'h105, 8'($urandom_range(0, 6)), "R9 same-cycle");
        7:  step(1, 0, 1, 10'h102, 8'h0, "R10 read+wake");
        8:  step(1, 0, 1, 10'h103, 8'h0, "R10 lo+wake");
        9:  rd_reg(10'($urandom_range('h100, 'h107)), "R1 rnd read");
        default: step(1, 0, 0, 10'h0, 8'h0, "R2 rnd wake");
      endcase
    end
    step(0, 0, 0, 10'h0, 8'h0, "idle");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule